// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of a byte-wide asynchronous NOR flash and turns one-word requests into the write and read cycles the flash needs. A request carries an operation code, a target address and a data byte. The block issues the unlock writes and the command write for that operation. For program and erase it then reads the device until the operation has finished, and it always leaves the device in read mode with a return-to-read write. Identify leaves the manufacturer and device codes on two output registers.

Each bus cycle is timed in whole clocks. A write holds chip enable low for a set-up period before the write strobe, keeps the write strobe low for a fixed pulse width and then holds for a few more clocks. A read waits an access time with output enable low before it samples. A configuration pin swaps the two command addresses for devices whose lowest address pin is wired one place over. A program request whose target already reads back the wanted byte finishes without any write.

Top module: `nor_cmd_seq`

## Requirements
- R1: Out of reset and whenever idle, `busy` and `ack` are low and `f_ce_n`, `f_we_n` and `f_oe_n` are all high.
- R2: A program request (op code 1) first reads the target. On a mismatch it writes 0xAA to 0x555, 0x55 to 0x2AA and 0xA0 to 0x555, then writes the data byte to the target address, and finally writes 0xF0 to address 0.
- R3: When the read of the target before a program equals the requested byte (0xFF on an erased byte included), the request completes with `ack` and no write cycle at all.
- R4: A sector erase (op code 2) writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555 and 0x55@0x2AA, then 0x30 to the target address with its low 16 bits cleared, and then 0xF0 to address 0. Only the 64 KB sector that holds the target is erased.
- R5: A chip erase (op code 3) issues the same first five writes as R4, then 0x10 to 0x555, then 0xF0 to address 0.
- R6: After the program write, the block reads the target repeatedly until it returns the written byte. After an erase command, it reads (sector base, or address 0 for chip erase) until it returns 0xFF. `ack` comes only after the matching read.
- R7: Identify (op code 4) writes the three-cycle command ending in 0x90@0x555 and reads the manufacturer code at address 0 into `id_mfr`. It writes 0xF0@0, repeats the command, reads the device code at address 1 into `id_dev`, and writes 0xF0@0 again.
- R8: With `cfg_shift_map` high, every write that would go to 0x555 goes to 0xAAA instead, and every write to 0x2AA goes to 0x555.
- R9: Every write drops `f_ce_n` exactly SETUP_CLKS clocks before `f_we_n` falls. It holds `f_we_n` low for exactly PULSE_CLKS clocks, with `f_addr` and `f_dout` stable while the strobe is low. `f_we_n` is never low while `f_ce_n` is high or `f_oe_n` is low.
- R10: If POLL_MAX completion reads all fail to match, the block still writes 0xF0@0, then pulses `ack` together with `err`.
- R11: A request is taken only while `busy` is low and only for op codes 1 to 5. Requests that arrive while busy, and op codes 0, 6 and 7, are dropped and not queued. `ack` is high for exactly one clock per accepted request.
- R12: A reset request (op code 5) issues a single write of 0xF0 to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_op | input | 3 | Operation code (1 program, 2 sector erase, 3 chip erase, 4 identify, 5 reset) |
| req_addr | input | ADDR_W | Target byte address |
| req_data | input | 8 | Byte to program |
| cfg_shift_map | input | 1 | Use the shifted command addresses 0xAAA/0x555 |
| busy | output | 1 | A request is in progress |
| ack | output | 1 | One-clock completion pulse |
| err | output | 1 | Completion timed out, valid with `ack` |
| id_mfr | output | 8 | Manufacturer code from the last identify |
| id_dev | output | 8 | Device code from the last identify |
| f_addr | output | ADDR_W | Flash address bus |
| f_dout | output | 8 | Flash write data |
| f_din | input | 8 | Flash read data |
| f_ce_n | output | 1 | Flash chip enable, active low |
| f_we_n | output | 1 | Flash write strobe, active low |
| f_oe_n | output | 1 | Flash output enable, active low |

## Verification
A wrong step index or operation register shows up at once as a write log that differs from the expected address/data list, usually in the first command write after acceptance. A broken completion compare shows up within one poll. It gives either an early `ack` while the flash model is still busy, a read count that is off, or a false `err` after exactly POLL_MAX reads. A broken cycle counter in the bus engine shows up on the very first write strobe as a wrong set-up or pulse width.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

   typedef enum logic [2:0] {
      OP_NONE   = 3'd0,
      OP_PROG   = 3'd1,
      OP_SERASE = 3'd2,
      OP_CERASE = 3'd3,
      OP_IDENT  = 3'd4,
      OP_RESET  = 3'd5
   } nor_op_e;

   typedef enum logic [2:0] {
      ST_WR,    // plain write cycle
      ST_CHK,   // read before program, skip on match
      ST_POLL,  // completion read, repeat until match
      ST_MFR,   // read manufacturer code
      ST_DEV,   // read device code
      ST_END    // sequence finished
   } step_kind_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_PULSE,
      PH_HOLD,
      PH_ACC
   } phy_st_e;

   localparam logic [7:0] K_UNLOCK_A = 8'hAA;
   localparam logic [7:0] K_UNLOCK_B = 8'h55;
   localparam logic [7:0] K_PROG     = 8'hA0;
   localparam logic [7:0] K_ERASE    = 8'h80;
   localparam logic [7:0] K_SECTOR   = 8'h30;
   localparam logic [7:0] K_CHIP     = 8'h10;
   localparam logic [7:0] K_IDENT    = 8'h90;
   localparam logic [7:0] K_READMODE = 8'hF0;
   localparam logic [7:0] K_BLANK    = 8'hFF;

endpackage

// File: rtl/nor_step_table.sv
module nor_step_table
   import nor_seq_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter bit ALT_MAP_EN = 1'b1
) (
   input  nor_op_e             op,
   input  logic [3:0]          idx,
   input  logic                alt,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [7:0]          data,
   output step_kind_e          kind,
   output logic [ADDR_W-1:0]   s_addr,
   output logic [7:0]          s_data
);

   localparam int SECT_BITS = 16;

   typedef struct packed {
      step_kind_e        k;
      logic [ADDR_W-1:0] a;
      logic [7:0]        d;
   } step_t;

   function automatic step_t mk(step_kind_e k, logic [ADDR_W-1:0] a, logic [7:0] d);
      step_t s;
      s.k = k;
      s.a = a;
      s.d = d;
      return s;
   endfunction

   logic              use_alt;
   logic [ADDR_W-1:0] cmd_a;
   logic [ADDR_W-1:0] cmd_b;
   logic [ADDR_W-1:0] sect_base;
   logic [ADDR_W-1:0] zero_a;
   logic [ADDR_W-1:0] one_a;
   step_t             s;

   generate
      if (ALT_MAP_EN) begin : g_alt_map
         assign use_alt = alt;
      end else begin : g_std_map
         logic unused_alt;
         assign unused_alt = alt;
         assign use_alt    = 1'b0;
      end
      if (ADDR_W < SECT_BITS + 1) begin : g_bad_width
         $error("nor_step_table: ADDR_W must exceed the sector offset width");
      end
   endgenerate

   assign cmd_a     = use_alt ? ADDR_W'(12'hAAA) : ADDR_W'(12'h555);
   assign cmd_b     = use_alt ? ADDR_W'(12'h555) : ADDR_W'(12'h2AA);
   assign sect_base = {addr[ADDR_W-1:SECT_BITS], {SECT_BITS{1'b0}}};
   assign zero_a    = '0;
   assign one_a     = ADDR_W'(1);

   always_comb begin
      s = mk(ST_END, zero_a, 8'h00);
      unique case (op)
         OP_PROG: begin
            case (idx)
               4'd0: s = mk(ST_CHK,  addr,   data);
               4'd1: s = mk(ST_WR,   cmd_a,  K_UNLOCK_A);
               4'd2: s = mk(ST_WR,   cmd_b,  K_UNLOCK_B);
               4'd3: s = mk(ST_WR,   cmd_a,  K_PROG);
               4'd4: s = mk(ST_WR,   addr,   data);
               4'd5: s = mk(ST_POLL, addr,   data);
               4'd6: s = mk(ST_WR,   zero_a, K_READMODE);
               default: s = mk(ST_END, zero_a, 8'h00);
            endcase
         end
         OP_SERASE, OP_CERASE: begin
            case (idx)
               4'd0: s = mk(ST_WR, cmd_a, K_UNLOCK_A);
               4'd1: s = mk(ST_WR, cmd_b, K_UNLOCK_B);
               4'd2: s = mk(ST_WR, cmd_a, K_ERASE);
               4'd3: s = mk(ST_WR, cmd_a, K_UNLOCK_A);
               4'd4: s = mk(ST_WR, cmd_b, K_UNLOCK_B);
               4'd5: s = (op == OP_SERASE) ? mk(ST_WR, sect_base, K_SECTOR)
                                           : mk(ST_WR, cmd_a, K_CHIP);
               4'd6: s = mk(ST_POLL, (op == OP_SERASE) ? sect_base : zero_a, K_BLANK);
               4'd7: s = mk(ST_WR, zero_a, K_READMODE);
               default: s = mk(ST_END, zero_a, 8'h00);
            endcase
         end
         OP_IDENT: begin
            case (idx)
               4'd0, 4'd5: s = mk(ST_WR, cmd_a, K_UNLOCK_A);
               4'd1, 4'd6: s = mk(ST_WR, cmd_b, K_UNLOCK_B);
               4'd2, 4'd7: s = mk(ST_WR, cmd_a, K_IDENT);
               4'd3:       s = mk(ST_MFR, zero_a, 8'h00);
               4'd8:       s = mk(ST_DEV, one_a, 8'h00);
               4'd4, 4'd9: s = mk(ST_WR, zero_a, K_READMODE);
               default:    s = mk(ST_END, zero_a, 8'h00);
            endcase
         end
         OP_RESET: begin
            if (idx == 4'd0) s = mk(ST_WR, zero_a, K_READMODE);
         end
         default: s = mk(ST_END, zero_a, 8'h00);
      endcase
   end

   assign kind   = s.k;
   assign s_addr = s.a;
   assign s_data = s.d;

endmodule

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle
   import nor_seq_pkg::*;
#(
   parameter int ADDR_W      = 20,
   parameter int SETUP_CLKS  = 2,
   parameter int PULSE_CLKS  = 2,
   parameter int HOLD_CLKS   = 1,
   parameter int ACCESS_CLKS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_wr,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [7:0]        data_in,
   output logic              done,
   output logic [7:0]        rdata,
   output logic [ADDR_W-1:0] f_addr,
   output logic [7:0]        f_dout,
   input  logic [7:0]        f_din,
   output logic              f_ce_n,
   output logic              f_we_n,
   output logic              f_oe_n
);

   localparam int MAX_A = (SETUP_CLKS > PULSE_CLKS) ? SETUP_CLKS : PULSE_CLKS;
   localparam int MAX_B = (HOLD_CLKS > ACCESS_CLKS) ? HOLD_CLKS : ACCESS_CLKS;
   localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CW    = $clog2(MAX_C + 1);

   generate
      if (SETUP_CLKS < 1 || PULSE_CLKS < 1 || HOLD_CLKS < 1 || ACCESS_CLKS < 1) begin : g_bad_timing
         $error("nor_bus_cycle: every phase needs at least one clock");
      end
   endgenerate

   phy_st_e           st;
   logic [CW-1:0]     cnt;
   logic [ADDR_W-1:0] a_q;
   logic [7:0]        d_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= PH_IDLE;
         cnt   <= '0;
         done  <= 1'b0;
         rdata <= 8'h00;
         a_q   <= '0;
         d_q   <= 8'h00;
      end else begin
         done <= 1'b0;
         unique case (st)
            PH_IDLE: begin
               if (start) begin
                  a_q <= addr_in;
                  d_q <= data_in;
                  cnt <= '0;
                  st  <= is_wr ? PH_SETUP : PH_ACC;
               end
            end
            PH_SETUP: begin
               if (cnt == CW'(SETUP_CLKS - 1)) begin
                  cnt <= '0;
                  st  <= PH_PULSE;
               end else cnt <= cnt + 1'b1;
            end
            PH_PULSE: begin
               if (cnt == CW'(PULSE_CLKS - 1)) begin
                  cnt <= '0;
                  st  <= PH_HOLD;
               end else cnt <= cnt + 1'b1;
            end
            PH_HOLD: begin
               if (cnt == CW'(HOLD_CLKS - 1)) begin
                  cnt  <= '0;
                  st   <= PH_IDLE;
                  done <= 1'b1;
               end else cnt <= cnt + 1'b1;
            end
            PH_ACC: begin
               if (cnt == CW'(ACCESS_CLKS - 1)) begin
                  cnt   <= '0;
                  st    <= PH_IDLE;
                  rdata <= f_din;
                  done  <= 1'b1;
               end else cnt <= cnt + 1'b1;
            end
            default: st <= PH_IDLE;
         endcase
      end
   end

   assign f_ce_n = (st == PH_IDLE);
   assign f_we_n = (st != PH_PULSE);
   assign f_oe_n = (st != PH_ACC);
   assign f_addr = a_q;
   assign f_dout = d_q;

   // R9: strobe only inside an enabled, non-read cycle
   p_we_under_ce_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !f_we_n |-> (!f_ce_n && f_oe_n));

   // R9: address and data frozen while the write strobe is low
   p_wr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!f_we_n && $past(!f_we_n)) |-> ($stable(f_addr) && $stable(f_dout)));

   // R9: strobe is preceded by an enabled set-up clock
   p_setup_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(f_we_n) |-> $past(!f_ce_n));

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
   import nor_seq_pkg::*;
#(
   parameter int ADDR_W      = 20,
   parameter int SETUP_CLKS  = 2,
   parameter int PULSE_CLKS  = 2,
   parameter int HOLD_CLKS   = 1,
   parameter int ACCESS_CLKS = 3,
   parameter int POLL_MAX    = 4096,
   parameter bit ALT_MAP_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [7:0]        req_data,
   input  logic              cfg_shift_map,
   output logic              busy,
   output logic              ack,
   output logic              err,
   output logic [7:0]        id_mfr,
   output logic [7:0]        id_dev,
   output logic [ADDR_W-1:0] f_addr,
   output logic [7:0]        f_dout,
   input  logic [7:0]        f_din,
   output logic              f_ce_n,
   output logic              f_we_n,
   output logic              f_oe_n
);

   localparam int PCW = $clog2(POLL_MAX + 1);

   generate
      if (POLL_MAX < 1) begin : g_bad_poll
         $error("nor_cmd_seq: POLL_MAX must be at least one");
      end
   endgenerate

   typedef enum logic [1:0] {T_IDLE, T_ISSUE, T_WAIT} top_st_e;

   top_st_e           st;
   nor_op_e           op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        data_q;
   logic              alt_q;
   logic [3:0]        idx;
   logic [PCW-1:0]    pcnt;
   logic              err_q;
   logic              op_ok;

   step_kind_e        kind;
   logic [ADDR_W-1:0] s_addr;
   logic [7:0]        s_data;
   logic              phy_start;
   logic              phy_done;
   logic [7:0]        phy_rdata;

   nor_step_table #(
      .ADDR_W     (ADDR_W),
      .ALT_MAP_EN (ALT_MAP_EN)
   ) u_table (
      .op     (op_q),
      .idx    (idx),
      .alt    (alt_q),
      .addr   (addr_q),
      .data   (data_q),
      .kind   (kind),
      .s_addr (s_addr),
      .s_data (s_data)
   );

   nor_bus_cycle #(
      .ADDR_W      (ADDR_W),
      .SETUP_CLKS  (SETUP_CLKS),
      .PULSE_CLKS  (PULSE_CLKS),
      .HOLD_CLKS   (HOLD_CLKS),
      .ACCESS_CLKS (ACCESS_CLKS)
   ) u_phy (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (phy_start),
      .is_wr   (kind == ST_WR),
      .addr_in (s_addr),
      .data_in (s_data),
      .done    (phy_done),
      .rdata   (phy_rdata),
      .f_addr  (f_addr),
      .f_dout  (f_dout),
      .f_din   (f_din),
      .f_ce_n  (f_ce_n),
      .f_we_n  (f_we_n),
      .f_oe_n  (f_oe_n)
   );

   assign op_ok     = (req_op >= 3'd1) && (req_op <= 3'd5);
   assign busy      = (st != T_IDLE);
   assign phy_start = (st == T_ISSUE) && (kind != ST_END);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= T_IDLE;
         op_q   <= OP_NONE;
         addr_q <= '0;
         data_q <= 8'h00;
         alt_q  <= 1'b0;
         idx    <= '0;
         pcnt   <= '0;
         err_q  <= 1'b0;
         ack    <= 1'b0;
         err    <= 1'b0;
         id_mfr <= 8'h00;
         id_dev <= 8'h00;
      end else begin
         ack <= 1'b0;
         err <= 1'b0;
         unique case (st)
            T_IDLE: begin
               if (req_valid && op_ok) begin
                  op_q   <= nor_op_e'(req_op);
                  addr_q <= req_addr;
                  data_q <= req_data;
                  alt_q  <= cfg_shift_map;
                  idx    <= '0;
                  pcnt   <= '0;
                  err_q  <= 1'b0;
                  st     <= T_ISSUE;
               end
            end
            T_ISSUE: begin
               if (kind == ST_END) begin
                  ack <= 1'b1;
                  err <= err_q;
                  st  <= T_IDLE;
               end else st <= T_WAIT;
            end
            T_WAIT: begin
               if (phy_done) begin
                  st <= T_ISSUE;
                  unique case (kind)
                     ST_CHK: begin
                        if (phy_rdata == data_q) begin
                           ack <= 1'b1;
                           st  <= T_IDLE;
                        end else idx <= idx + 1'b1;
                     end
                     ST_POLL: begin
                        if (phy_rdata == s_data) begin
                           idx <= idx + 1'b1;
                        end else if (pcnt == PCW'(POLL_MAX - 1)) begin
                           err_q <= 1'b1;
                           idx   <= idx + 1'b1;
                        end else pcnt <= pcnt + 1'b1;
                     end
                     ST_MFR: begin
                        id_mfr <= phy_rdata;
                        idx    <= idx + 1'b1;
                     end
                     ST_DEV: begin
                        id_dev <= phy_rdata;
                        idx    <= idx + 1'b1;
                     end
                     default: idx <= idx + 1'b1;
                  endcase
               end
            end
            default: st <= T_IDLE;
         endcase
      end
   end

   // R1: an idle sequencer leaves the flash bus parked
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (f_ce_n && f_we_n && f_oe_n));

   // R11: completion pulse lasts one clock
   p_ack_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);

   // R11: completion only ends a request that was in progress
   p_ack_after_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> ($past(busy) && !busy));

   // R10: the timeout flag travels with the completion pulse
   p_err_with_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> ack);

endmodule

// File: tb/tb_nor_cmd_seq.sv
`timescale 1ns/1ps
module tb_nor_cmd_seq;

   localparam int AW     = 20;
   localparam int SETUP  = 2;
   localparam int PULSE  = 3;
   localparam int HOLD   = 1;
   localparam int ACCESS = 2;
   localparam int PMAX   = 8;
   localparam int BUSYN  = 3;
   localparam logic [7:0] MFR_CODE = 8'h5A;
   localparam logic [7:0] DEV_CODE = 8'hC3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [2:0]    req_op = 3'd0;
   logic [AW-1:0] req_addr = '0;
   logic [7:0]    req_data = 8'h00;
   logic          alt_cfg = 1'b0;
   logic          busy, ack, err;
   logic [7:0]    id_mfr, id_dev;
   logic [AW-1:0] f_addr;
   logic [7:0]    f_dout, f_din;
   logic          f_ce_n, f_we_n, f_oe_n;

   always #4 clk = ~clk;

   nor_cmd_seq #(
      .ADDR_W(AW), .SETUP_CLKS(SETUP), .PULSE_CLKS(PULSE), .HOLD_CLKS(HOLD),
      .ACCESS_CLKS(ACCESS), .POLL_MAX(PMAX), .ALT_MAP_EN(1'b1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_data(req_data), .cfg_shift_map(alt_cfg),
      .busy(busy), .ack(ack), .err(err), .id_mfr(id_mfr), .id_dev(id_dev),
      .f_addr(f_addr), .f_dout(f_dout), .f_din(f_din),
      .f_ce_n(f_ce_n), .f_we_n(f_we_n), .f_oe_n(f_oe_n)
   );

   int n_checks = 0;
   int n_errors = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s act=0x%0h exp=0x%0h", req, what, act, exp);
      end
   endtask

   // ---------------- flash model ----------------
   localparam int M_READ = 0, M_PBUSY = 1, M_EBUSY = 2, M_ID = 3;
   logic [7:0]    fmem [0:4095];
   int            m_mode = M_READ;
   int            m_uc = 0;
   int            m_left = 0;
   bit            m_stuck = 1'b0;
   logic [7:0]    m_pexp = 8'h00;
   logic [AW-1:0] log_a [0:63];
   logic [7:0]    log_d [0:63];
   int            log_n = 0;
   int            rd_cnt = 0;

   function automatic logic [11:0] midx(input logic [AW-1:0] a);
      return {a[19:16], a[7:0]};
   endfunction

   assign f_din = (m_mode == M_ID)    ? (f_addr[0] ? DEV_CODE : MFR_CODE) :
                  (m_mode == M_PBUSY) ? ~m_pexp :
                  (m_mode == M_EBUSY) ? 8'h00 : fmem[midx(f_addr)];

   task automatic m_write(input logic [AW-1:0] a, input logic [7:0] d);
      logic [11:0] c0, c1;
      c0 = alt_cfg ? 12'hAAA : 12'h555;
      c1 = alt_cfg ? 12'h555 : 12'h2AA;
      log_a[log_n] = a;
      log_d[log_n] = d;
      if (log_n < 63) log_n++;
      if (d == 8'hF0) begin
         m_mode = M_READ;
         m_uc = 0;
      end else begin
         case (m_uc)
            0: m_uc = (a[11:0] == c0 && d == 8'hAA) ? 1 : 0;
            1: m_uc = (a[11:0] == c1 && d == 8'h55) ? 2 : 0;
            2: begin
               if (a[11:0] == c0 && d == 8'hA0) m_uc = 3;
               else if (a[11:0] == c0 && d == 8'h80) m_uc = 4;
               else if (a[11:0] == c0 && d == 8'h90) begin m_mode = M_ID; m_uc = 0; end
               else m_uc = 0;
            end
            3: begin
               fmem[midx(a)] = fmem[midx(a)] & d;
               m_pexp = d;
               m_mode = M_PBUSY;
               m_left = BUSYN;
               m_uc = 0;
            end
            4: m_uc = (a[11:0] == c0 && d == 8'hAA) ? 5 : 0;
            5: m_uc = (a[11:0] == c1 && d == 8'h55) ? 6 : 0;
            6: begin
               if (d == 8'h10 && a[11:0] == c0) begin
                  for (int j = 0; j < 4096; j++) fmem[j] = 8'hFF;
                  m_mode = M_EBUSY;
                  m_left = BUSYN;
               end else if (d == 8'h30) begin
                  for (int j = 0; j < 256; j++) fmem[{a[19:16], 8'(j)}] = 8'hFF;
                  m_mode = M_EBUSY;
                  m_left = BUSYN;
               end
               m_uc = 0;
            end
            default: m_uc = 0;
         endcase
      end
   endtask

   always @(posedge f_we_n) if (rst_n) m_write(f_addr, f_dout);

   always @(posedge f_oe_n) begin
      if (rst_n) begin
         rd_cnt++;
         if (m_mode == M_PBUSY || m_mode == M_EBUSY) begin
            if (m_left > 0) m_left--;
            if (m_left == 0 && !m_stuck) m_mode = M_READ;
         end
      end
   end

   // ---------------- strobe timing monitor (R9) ----------------
   int            su_cnt = 0;
   int            pw_cnt = 0;
   bit            in_pulse = 1'b0;
   int            pulses = 0;
   logic [AW-1:0] p_a;
   logic [7:0]    p_d;

   always @(negedge clk) begin
      if (rst_n) begin
         if (f_ce_n) su_cnt = 0;
         else if (f_we_n && !in_pulse) su_cnt++;
         if (!f_we_n) begin
            if (!in_pulse) begin
               in_pulse = 1'b1;
               pw_cnt = 0;
               p_a = f_addr;
               p_d = f_dout;
               pulses++;
               chk(su_cnt == SETUP, "R9", "setup clocks", su_cnt, SETUP);
            end
            pw_cnt++;
            if (f_addr != p_a || f_dout != p_d)
               chk(1'b0, "R9", "addr/data moved in pulse", int'(f_addr), int'(p_a));
         end else if (in_pulse) begin
            in_pulse = 1'b0;
            chk(pw_cnt == PULSE, "R9", "pulse clocks", pw_cnt, PULSE);
         end
      end
   end

   // ---------------- expected write list ----------------
   logic [AW-1:0] ex_a [0:63];
   logic [7:0]    ex_d [0:63];
   int            ex_n = 0;

   task automatic ex(input logic [AW-1:0] a, input logic [7:0] d);
      ex_a[ex_n] = a;
      ex_d[ex_n] = d;
      ex_n++;
   endtask

   task automatic ex_cmd(input bit alt, input logic [7:0] cmd);
      logic [AW-1:0] c0, c1;
      c0 = alt ? AW'(12'hAAA) : AW'(12'h555);
      c1 = alt ? AW'(12'h555) : AW'(12'h2AA);
      ex(c0, 8'hAA);
      ex(c1, 8'h55);
      ex(c0, cmd);
   endtask

   task automatic chk_log(input string req);
      bit ok;
      int bad;
      ok = (log_n == ex_n);
      bad = -1;
      if (ok)
         for (int i = 0; i < ex_n; i++)
            if (bad < 0 && (log_a[i] != ex_a[i] || log_d[i] != ex_d[i])) bad = i;
      if (bad >= 0) begin
         ok = 1'b0;
         chk(ok, req, $sformatf("write %0d addr/data", bad),
             int'({log_a[bad], log_d[bad]}), int'({ex_a[bad], ex_d[bad]}));
      end else begin
         chk(ok, req, "write count", log_n, ex_n);
      end
   endtask

   // ---------------- request driver ----------------
   bit got_ack, got_err, ack_after;

   task automatic run_op(input logic [2:0] op, input logic [AW-1:0] a, input logic [7:0] d);
      log_n = 0;
      rd_cnt = 0;
      ex_n = 0;
      got_ack = 1'b0;
      got_err = 1'b0;
      @(negedge clk);
      req_valid = 1'b1;
      req_op = op;
      req_addr = a;
      req_data = d;
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < 4000 && !got_ack; i++) begin
         if (ack) begin
            got_ack = 1'b1;
            got_err = err;
         end else @(negedge clk);
      end
      if (!got_ack) chk(1'b0, "R11", "no ack (timeout)", 0, 1);
      @(negedge clk);
      ack_after = ack;
   endtask

   // ---------------- watchdog ----------------
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   // ---------------- test sequence ----------------
   initial begin
      logic [AW-1:0] a;
      logic [7:0]    d;
      for (int j = 0; j < 4096; j++) fmem[j] = 8'hFF;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!busy && !ack, "R1", "busy/ack after reset", {busy, ack}, 0);
      chk(f_ce_n && f_we_n && f_oe_n, "R1", "bus strobes after reset",
          {f_ce_n, f_we_n, f_oe_n}, 3'b111);

      // R2 / R8 / R6: program sweep in both address maps
      for (int alt = 0; alt < 2; alt++) begin
         alt_cfg = alt[0];
         for (int k = 0; k < 6; k++) begin
            a = AW'((k + 1) * 20'h10000 + k * 3 + alt * 64);
            d = 8'(k * 29 + alt * 7 + 3);
            run_op(3'd1, a, d);
            ex_cmd(alt[0], 8'hA0);
            ex(a, d);
            ex('0, 8'hF0);
            chk_log(alt ? "R8" : "R2");
            chk(got_ack && !got_err, "R2", "program ack/err", {got_ack, got_err}, 2'b10);
            chk(fmem[midx(a)] == d, "R6", "programmed byte", fmem[midx(a)], d);
            chk(rd_cnt == BUSYN + 2, "R6", "reads during program", rd_cnt, BUSYN + 2);
            chk(!ack_after, "R11", "ack width", ack_after, 0);
         end
      end

      // R3: skip when target already matches
      alt_cfg = 1'b0;
      run_op(3'd1, 20'h1_0000, 8'd3);
      chk(got_ack && log_n == 0, "R3", "match skip writes", log_n, 0);
      run_op(3'd1, 20'h1_00F0, 8'hFF);
      chk(got_ack && log_n == 0, "R3", "blank 0xFF skip writes", log_n, 0);

      // R4: sector erase of sector 2 (holds data at 0x20003)
      run_op(3'd2, 20'h2_0034, 8'h00);
      ex_cmd(1'b0, 8'h80);
      ex(AW'(12'h555), 8'hAA);
      ex(AW'(12'h2AA), 8'h55);
      ex(20'h2_0000, 8'h30);
      ex('0, 8'hF0);
      chk_log("R4");
      chk(fmem[midx(20'h2_0003)] == 8'hFF, "R4", "erased byte", fmem[midx(20'h2_0003)], 8'hFF);
      chk(fmem[midx(20'h3_0006)] == 8'd61, "R4", "neighbour sector kept",
          fmem[midx(20'h3_0006)], 61);
      chk(rd_cnt == BUSYN + 1, "R6", "reads during erase", rd_cnt, BUSYN + 1);

      // R8: sector erase with shifted map
      alt_cfg = 1'b1;
      run_op(3'd2, 20'h3_0099, 8'h00);
      ex_cmd(1'b1, 8'h80);
      ex(AW'(12'hAAA), 8'hAA);
      ex(AW'(12'h555), 8'h55);
      ex(20'h3_0000, 8'h30);
      ex('0, 8'hF0);
      chk_log("R8");
      chk(fmem[midx(20'h3_0006)] == 8'hFF, "R8", "shifted-map erase", fmem[midx(20'h3_0006)], 8'hFF);

      // R7: identify
      alt_cfg = 1'b0;
      run_op(3'd4, '0, 8'h00);
      ex_cmd(1'b0, 8'h90);
      ex('0, 8'hF0);
      ex_cmd(1'b0, 8'h90);
      ex('0, 8'hF0);
      chk_log("R7");
      chk(id_mfr == MFR_CODE, "R7", "manufacturer code", id_mfr, MFR_CODE);
      chk(id_dev == DEV_CODE, "R7", "device code", id_dev, DEV_CODE);
      chk(rd_cnt == 2, "R7", "identify reads", rd_cnt, 2);

      // R12: reset request
      run_op(3'd5, 20'h7_1234, 8'h00);
      ex('0, 8'hF0);
      chk_log("R12");

      // R10: completion never seen
      m_stuck = 1'b1;
      run_op(3'd1, 20'h5_0080, 8'h12);
      m_stuck = 1'b0;
      ex_cmd(1'b0, 8'hA0);
      ex(20'h5_0080, 8'h12);
      ex('0, 8'hF0);
      chk_log("R10");
      chk(got_ack && got_err, "R10", "timeout err with ack", {got_ack, got_err}, 2'b11);
      chk(rd_cnt == PMAX + 1, "R10", "poll reads before timeout", rd_cnt, PMAX + 1);

      // R5 + R11: chip erase with a request dropped while busy
      log_n = 0;
      rd_cnt = 0;
      ex_n = 0;
      got_ack = 1'b0;
      @(negedge clk);
      req_valid = 1'b1;
      req_op = 3'd3;
      req_addr = 20'h4_0000;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (5) @(negedge clk);
      chk(busy, "R11", "busy during chip erase", busy, 1);
      req_valid = 1'b1;
      req_op = 3'd5;
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < 4000 && !got_ack; i++) begin
         if (ack) got_ack = 1'b1;
         else @(negedge clk);
      end
      chk(got_ack, "R5", "chip erase ack", got_ack, 1);
      ex_cmd(1'b0, 8'h80);
      ex(AW'(12'h555), 8'hAA);
      ex(AW'(12'h2AA), 8'h55);
      ex(AW'(12'h555), 8'h10);
      ex('0, 8'hF0);
      chk_log("R5");
      chk(fmem[midx(20'h4_0009)] == 8'hFF, "R5", "chip erased byte", fmem[midx(20'h4_0009)], 8'hFF);
      repeat (4) @(negedge clk);
      chk(!busy && log_n == ex_n, "R11", "busy request not queued", log_n, ex_n);

      // R11: undefined op codes ignored
      foreach (ex_a[i]) if (i == 0) ex_n = 0;
      for (int k = 0; k < 3; k++) begin
         log_n = 0;
         @(negedge clk);
         req_valid = 1'b1;
         req_op = (k == 0) ? 3'd0 : 3'(k + 5);
         @(negedge clk);
         req_valid = 1'b0;
         chk(!busy, "R11", "bad op not accepted", busy, 0);
         repeat (3) @(negedge clk);
         chk(log_n == 0 && f_ce_n, "R11", "bad op no bus cycle", log_n, 0);
      end

      // R9: monitor saw strobes
      chk(pulses > 0, "R9", "write strobes observed", pulses, 1);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule